// File: doc/BRIEF.md
# Segmented Run-of-Ones Detector

The detector takes a wide data word, cuts it into equal segments that do not overlap, and raises one flag per segment when that segment holds a run of at least a minimum number of adjacent one bits. A run that is longer than the minimum contains the minimum run, so it raises the flag as well. Each segment is judged only on its own bits. A run that crosses from one segment into the next counts for neither segment, unless one side of the boundary holds the full run by itself.

The work takes two register stages. The first stage stores, for every window position inside a segment, whether all bits of that window are one. The second stage ORs those window results into the segment flag. A new word can be presented on every clock, and its flags appear two clocks later. The segment count, segment width and run length are parameters. Elaboration stops when the run length is zero or is greater than the segment width.

Top module: `seg_run_detect`

## Requirements
- R1: With default parameters the 2040-bit word forms 24 segments of 85 bits. Segment k covers data bits k*85 to k*85+84, with bit 0 the first bit of segment 0. Flag bit k reports segment k and no other segment.
- R2: Flag k is 1 exactly when segment k contains 5 adjacent one bits starting at some offset from 0 to 80 inside the segment. A run of 4 or fewer ones does not set it.
- R3: A run longer than 5 ones, up to the whole segment, sets the flag of the segment that contains it.
- R4: Ones that span a segment boundary set neither segment's flag unless one of the two segments alone holds 5 adjacent ones. In that case only the flag of that segment is set.
- R5: The flags for a word applied before clock edge n are visible after edge n+1. Words can change on every cycle, and each word gets its own result.
- R6: While the synchronous active-high reset `rst` is sampled high, the flags go to zero. Words that were present during reset, or in the cycle just before reset, produce only zero flags.
- R7: A word that is all ones gives all flags at 1.
- R8: A word that is all zeros, or that alternates one and zero bits in either phase, gives all flags at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_i | input | NUM_SEG*SEG_W (2040) | Data word; segment k is data_i[k*SEG_W +: SEG_W] |
| flags_o | output | NUM_SEG (24) | Per-segment run flags, bit k for segment k |

## Verification
On every cycle, the assertions check the two-cycle relation between `data_i` and `flags_o`. They compare against a run-length count that has no windows, starting from the second cycle after reset. They also check the all-ones and all-zeros cases and the zero flags right after reset. Some behaviour is visible only at the ports, through the bench's chosen words:
- the segment-to-flag mapping,
- runs placed exactly at the first and last window offsets,
- four-bit near misses,
- the exact split of runs across boundaries,
- a reset asserted in the middle of a stream of back-to-back words.

// File: rtl/seg_run_pkg.sv
package seg_run_pkg;

   // Number of run-length windows that fit inside one segment.
   function automatic int unsigned win_count(input int unsigned seg_w,
                                             input int unsigned run_len);
      return (run_len > seg_w) ? 0 : (seg_w - run_len + 1);
   endfunction

   // Stage identifiers used in descriptive text of the checks.
   typedef enum logic [0:0] {
      STG_WINDOW = 1'b0,
      STG_FLAG   = 1'b1
   } seg_run_stage_e;

   localparam int unsigned SEG_RUN_LATENCY = 2;

endpackage

// File: rtl/seg_run_win.sv
module seg_run_win #(
   parameter int unsigned SEG_W   = 85,
   parameter int unsigned RUN_LEN = 5
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic [SEG_W-1:0]       seg_i,
   output logic [SEG_W-RUN_LEN:0] win_o
);
   import seg_run_pkg::*;

   localparam int unsigned WIN_N = win_count(SEG_W, RUN_LEN);

   logic [WIN_N-1:0] win_d;

   generate
      if (RUN_LEN == 1) begin : g_direct
         // A single-bit run: each bit is its own window.
         assign win_d = seg_i;
      end else begin : g_and
         for (genvar w = 0; w < WIN_N; w++) begin : g_w
            assign win_d[w] = &seg_i[w +: RUN_LEN];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) win_o <= '0;
      else     win_o <= win_d;
   end

endmodule

// File: rtl/seg_run_or.sv
module seg_run_or #(
   parameter int unsigned WIN_N = 81
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIN_N-1:0] win_i,
   output logic             flag_o
);

   always_ff @(posedge clk) begin
      if (rst) flag_o <= 1'b0;
      else     flag_o <= |win_i;
   end

endmodule

// File: rtl/seg_run_detect.sv
module seg_run_detect #(
   parameter int unsigned NUM_SEG = 24,
   parameter int unsigned SEG_W   = 85,
   parameter int unsigned RUN_LEN = 5
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NUM_SEG*SEG_W-1:0] data_i,
   output logic [NUM_SEG-1:0]       flags_o
);
   import seg_run_pkg::*;

   localparam int unsigned DATA_W = NUM_SEG * SEG_W;
   localparam int unsigned WIN_N  = win_count(SEG_W, RUN_LEN);

   generate
      if (RUN_LEN > SEG_W) begin : g_bad_run
         $error("seg_run_detect: RUN_LEN exceeds SEG_W");
      end
      if (RUN_LEN < 1) begin : g_bad_zero
         $error("seg_run_detect: RUN_LEN must be at least 1");
      end
      if (NUM_SEG < 1) begin : g_bad_seg
         $error("seg_run_detect: NUM_SEG must be at least 1");
      end
   endgenerate

   generate
      for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
         logic [WIN_N-1:0] win_q;

         seg_run_win #(
            .SEG_W   (SEG_W),
            .RUN_LEN (RUN_LEN)
         ) u_win (
            .clk   (clk),
            .rst   (rst),
            .seg_i (data_i[k*SEG_W +: SEG_W]),
            .win_o (win_q)
         );

         seg_run_or #(
            .WIN_N (WIN_N)
         ) u_or (
            .clk    (clk),
            .rst    (rst),
            .win_i  (win_q),
            .flag_o (flags_o[k])
         );
      end
   endgenerate

   // ---------------------------------------------------------------
   // Checks: reference by run counting, no windows involved
   // ---------------------------------------------------------------
   logic [NUM_SEG-1:0] ref_hit;
   logic [1:0]         live_q;
   logic               rst_q;

   generate
      for (genvar k = 0; k < NUM_SEG; k++) begin : g_ref
         always_comb begin
            int unsigned run_c;
            run_c      = 0;
            ref_hit[k] = 1'b0;
            for (int b = 0; b < int'(SEG_W); b++) begin
               if (data_i[k*SEG_W + b]) run_c = run_c + 1;
               else                     run_c = 0;
               if (run_c >= RUN_LEN) ref_hit[k] = 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      rst_q <= rst;
      if (rst)                 live_q <= 2'd0;
      else if (live_q != 2'd2) live_q <= live_q + 2'd1;
   end

   // R6: flags are cleared on the edge after reset is seen
   always_ff @(posedge clk) begin
      if (rst_q === 1'b1) begin
         p_reset_clear_r6: assert (flags_o == '0)
            else $error("flags not cleared after reset");
      end
   end

   // R2 / R5: two-cycle latency, matched against run counting
   p_flag_latency_r5: assert property (@(posedge clk) disable iff (rst)
      (live_q == 2'd2) |-> (flags_o == $past(ref_hit, 2)))
      else $error("flags differ from run count two cycles back");

   // R7: all-ones word sets every flag
   p_all_ones_r7: assert property (@(posedge clk) disable iff (rst)
      ((live_q == 2'd2) && $past(&data_i, 2)) |-> (&flags_o))
      else $error("all-ones word left a flag low");

   // R8: all-zeros word clears every flag
   p_all_zero_r8: assert property (@(posedge clk) disable iff (rst)
      ((live_q == 2'd2) && $past(data_i == '0, 2)) |-> (flags_o == '0))
      else $error("all-zeros word set a flag");

endmodule

// File: tb/seg_run_detect_bench.sv
module seg_run_detect_bench;
   localparam int NS = 24;
   localparam int SW = 85;
   localparam int RL = 5;
   localparam int DW = NS * SW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [DW-1:0] data_i = '0;
   logic [NS-1:0] flags_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [NS-1:0] exp_q[$];
   string         tag_q[$];

   always #2 clk = ~clk;

   seg_run_detect u_seg_run_detect (
      .clk     (clk),
      .rst     (rst),
      .data_i  (data_i),
      .flags_o (flags_o)
   );

   function automatic logic [NS-1:0] model(input logic [DW-1:0] d);
      logic [NS-1:0] f;
      f = '0;
      for (int k = 0; k < NS; k++) begin
         int run;
         run = 0;
         for (int b = 0; b < SW; b++) begin
            run = d[k*SW + b] ? run + 1 : 0;
            if (run >= RL) f[k] = 1'b1;
         end
      end
      return f;
   endfunction

   function automatic logic [DW-1:0] put_ones(input logic [DW-1:0] d,
                                              input int start, input int len);
      logic [DW-1:0] r;
      r = d;
      for (int i = start; i < start + len; i++) r[i] = 1'b1;
      return r;
   endfunction

   function automatic logic [DW-1:0] alt_word(input bit phase);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = ((i % 2) == 0) ^ phase;
      return r;
   endfunction

   // One clock: drive word, record expectation, compare the word from one cycle back.
   task automatic step(input logic [DW-1:0] d, input bit r, input string tag);
      @(negedge clk);
      if (r && exp_q.size() > 0) exp_q[exp_q.size()-1] = '0;
      rst    = r;
      data_i = d;
      exp_q.push_back(r ? '0 : model(d));
      tag_q.push_back(tag);
      @(posedge clk);
      @(negedge clk);
      if (exp_q.size() >= 2) begin
         logic [NS-1:0] e;
         string         t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (flags_o !== e) begin
            errors++;
            $display("FAIL %s: flags_o=%h expected=%h", t, flags_o, e);
         end
      end
   endtask

   task automatic flush(input string tag);
      step('0, 1'b0, tag);
      step('0, 1'b0, tag);
   endtask

   initial begin
      logic [DW-1:0] d;
      // R6: reset with an all-ones word present
      for (int i = 0; i < 3; i++) step('1, 1'b1, "R6 reset");
      step('0, 1'b0, "R6 reset");
      // R8: zeros and alternating
      step('0, 1'b0, "R8 zeros");
      step(alt_word(1'b0), 1'b0, "R8 alt0");
      step(alt_word(1'b1), 1'b0, "R8 alt1");
      // R7
      step('1, 1'b0, "R7 ones");
      step('1, 1'b0, "R7 ones");
      // R1: a run in segment k alone lights only flag k
      for (int k = 0; k < NS; k++) step(put_ones('0, k*SW + 40, RL), 1'b0, "R1 map");
      // R2: first and last window offsets, and four-bit near miss
      step(put_ones('0, 0, RL), 1'b0, "R2 first");
      step(put_ones('0, 23*SW + 80, RL), 1'b0, "R2 last");
      step(put_ones('0, 10*SW + 30, RL-1), 1'b0, "R2 four");
      d = '0;
      for (int k = 0; k < NS; k += 2) d = put_ones(d, k*SW + (k*7) % 81, RL);
      step(d, 1'b0, "R2 even");
      // R3: longer runs
      step(put_ones('0, 3*SW + 10, 20), 1'b0, "R3 long");
      step(put_ones('0, 7*SW, SW), 1'b0, "R3 full");
      // R4: boundary splits
      step(put_ones('0, 83, 5), 1'b0, "R4 2+3");
      step(put_ones('0, 82, 5), 1'b0, "R4 3+2");
      step(put_ones('0, 80, 7), 1'b0, "R4 5+2");
      step(put_ones('0, 84, 5), 1'b0, "R4 1+4");
      step(put_ones('0, 84, 6), 1'b0, "R4 1+5");
      step(put_ones('0, 5*SW + 81, 8), 1'b0, "R4 4+4");
      // R5: back-to-back distinct words
      for (int i = 0; i < 40; i++) begin
         d = '0;
         for (int b = 0; b < DW; b++) d[b] = ($urandom % 4) != 0;
         step(d, 1'b0, "R5 stream");
      end
      // R6: reset in mid-stream
      step('1, 1'b0, "R6 mid");
      step('1, 1'b1, "R6 mid");
      step('1, 1'b0, "R6 mid");
      step('1, 1'b0, "R6 mid");
      // R2: dense random words
      for (int i = 0; i < 150; i++) begin
         d = '0;
         for (int b = 0; b < DW; b++) d[b] = ($urandom % 3) != 0;
         step(d, 1'b0, "R2 random");
      end
      flush("R5 drain");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule